// File: doc/BRIEF.md
# Serial Port Host Register File and Interrupt Controller

This block is the host-facing register bank of a classic eight-register serial port. A host reaches it through a 3-bit offset, separate read and write strobes and 8-bit data buses. Reads are combinational within the strobe cycle, and their side effects take place at the clock edge that ends that cycle. Received bytes come in on a valid/byte pair and wait in a receive queue until the host reads them. Bytes the host writes for transmission leave on a registered valid/byte pair one cycle after the write. Bit timing, baud generation and the line itself belong to other blocks.

The block holds the divisor bytes, the interrupt enables, the line, FIFO and modem control values, a read-only modem status value and a scratch byte. It tracks three interrupt sources in a fixed priority and reports the winner through an identification code. It also drives one level-sensitive interrupt line.

Top module: `sio_host_regs`

## Requirements
- R1: After reset, offset 5 reads 0x60, offset 2 reads 0xC1, offsets 0, 1, 3, 4, 6 and 7 read 0x00, and both `irq` and `tx_valid` are low.
- R2: Offsets 3 (line control), 4 (modem control) and 7 (scratch) read back what was last written to them. A write to offset 2 stores the FIFO control byte and does not change what offset 2 reads. Writes to offset 5 (line status) and offset 6 (modem status, which reads 0x00) change nothing.
- R3: While bit 7 of line control is set, offsets 0 and 1 read and write the low and high divisor bytes. In that state a write to offset 0 sends no byte, and a read of offset 0 does not take a byte from the receive queue.
- R4: With bit 7 of line control clear, a write to offset 1 keeps only bits 3:0 as the interrupt enables, and a read of offset 1 returns them with bits 7:4 at zero.
- R5: With bit 7 of line control clear, a write to offset 0 marks the transmit-empty interrupt pending and, in the next cycle, pulses `tx_valid` for one cycle with that byte. The exception is byte 0xFF, which sets the interrupt but is not sent.
- R6: An incoming byte is queued, sets line status bit 0 (offset 5 reads 0x61) and marks the receive interrupt pending.
- R7: With bit 7 of line control clear, reading offset 0 returns bytes in arrival order and removes each one. Reading an empty queue returns 0x00. The read that empties the queue clears line status bit 0 and the receive pending interrupt.
- R8: The queue holds 16 bytes. A byte that arrives while 16 are waiting is dropped, and the first 16 bytes remain intact.
- R9: Offset 2 reads 0xC0 OR a code. The code is 0x0C when receive is pending with enable bit 0 set. Otherwise it is 0x02 when transmit-empty is pending with enable bit 1 set. Otherwise it is 0x00 when modem status is pending with enable bit 3 set. Otherwise it is 0x01. A disabled source stays pending.
- R10: A read of offset 2 that reports code 0x02 clears the transmit-empty pending bit. A read that reports any other code leaves that bit unchanged.
- R11: `irq` is high exactly when, in the previous cycle, the code was not 0x01.
- R12: A host write and an incoming byte in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the read strobe |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte valid, one-cycle pulse |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench checks that a priority encoder which lets transmit-empty win while received data waits would read 0xC2 instead of 0xCC. It also checks that an identification read which clears the transmit bit whatever code it reports would lose that interrupt once the receive queue drains. The bench overfills the queue: a queue that wraps when full would return a late byte in place of one of the first sixteen. It checks the divisor-latch mode, where a decoder that ignores line-control bit 7 would pop data or send a byte. It also drives a register write and an incoming byte in the same cycle, where the block must apply both.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned DW = 8;

  // register offsets: these positions are what host software decodes
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_ID   = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTS = 3'd5;
  localparam logic [2:0] OFS_MSTS = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int unsigned LATCH_BIT = 7;
  localparam logic [DW-1:0] NO_SEND = 8'hFF;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_THRE  = 4'h2,
    ID_RXTO  = 4'hC
  } id_code_e;

  // three-source priority: receive, then transmit-empty, then modem
  function automatic id_code_e pick_code(input logic rx_p, input logic th_p,
                                         input logic ms_p, input logic [3:0] en);
    if (rx_p && en[0])      return ID_RXTO;
    else if (th_p && en[1]) return ID_THRE;
    else if (ms_p && en[3]) return ID_MODEM;
    else                    return ID_NONE;
  endfunction

  // identification read value: top two bits forced high
  function automatic logic [DW-1:0] id_read(input id_code_e c);
    return {4'hC, 4'(c)};
  endfunction

  // line status: both transmit-empty bits always set, bit 0 is data ready
  function automatic logic [DW-1:0] lsts_value(input logic ready);
    return {1'b0, 1'b1, 1'b1, 4'b0000, ready};
  endfunction

endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drained
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);
  localparam logic [CW-1:0] CONE = CW'(1);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CFULL);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drained = pop_ok && (cnt == CONE) && !push_ok;
  assign dout    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CONE;
        2'b01:   cnt <= cnt - CONE;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CFULL);  // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);  // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> empty);  // R7

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ien,
  input  logic       rx_set,
  input  logic       rx_clr,
  input  logic       th_set,
  input  logic       ms_set,
  input  logic       id_rd,
  output id_code_e   code,
  output logic       rx_pend,
  output logic       th_pend,
  output logic       irq
);

  logic ms_pend;
  logic th_clr;

  assign code   = pick_code(rx_pend, th_pend, ms_pend, ien);
  assign th_clr = id_rd && (code == ID_THRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pend <= 1'b0;
      th_pend <= 1'b0;
      ms_pend <= 1'b0;
      irq     <= 1'b0;
    end else begin
      // a new arrival outranks a drain in the same cycle
      if (rx_set)      rx_pend <= 1'b1;
      else if (rx_clr) rx_pend <= 1'b0;
      // a new data write outranks an identification read
      if (th_set)      th_pend <= 1'b1;
      else if (th_clr) th_pend <= 1'b0;
      if (ms_set)      ms_pend <= 1'b1;
      irq <= (code != ID_NONE);
    end
  end

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(code) != ID_NONE)));  // R11
  AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && code == ID_THRE && !th_set) |=> !th_pend);  // R10
  AST_THR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && code != ID_THRE && th_pend) |=> th_pend);  // R10

endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
  import sio_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   addr,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic         rx_valid,
  input  logic [7:0]   rx_byte,
  output logic         tx_valid,
  output logic [7:0]   tx_byte,
  output logic         irq
);

  logic [7:0] div_lo, div_hi, lctl, fctl, mctl, scr;
  logic [3:0] ien;
  logic [7:0] msts;
  logic       latch;

  // named decode events
  logic ev_tx_wr, ev_rx_rd, ev_id_rd, ev_ien_wr;
  logic ev_div_lo_wr, ev_div_hi_wr;

  logic [7:0] q_head;
  logic       q_empty, q_full, q_drained;
  logic       rx_pend, th_pend;
  id_code_e   code;

  assign msts  = '0;
  assign latch = lctl[LATCH_BIT];

  assign ev_tx_wr     = wr_en && (addr == OFS_DATA) && !latch;
  assign ev_div_lo_wr = wr_en && (addr == OFS_DATA) &&  latch;
  assign ev_ien_wr    = wr_en && (addr == OFS_IEN)  && !latch;
  assign ev_div_hi_wr = wr_en && (addr == OFS_IEN)  &&  latch;
  assign ev_rx_rd     = rd_en && (addr == OFS_DATA) && !latch;
  assign ev_id_rd     = rd_en && (addr == OFS_ID);

  sio_rx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rx_valid),
    .din     (rx_byte),
    .pop     (ev_rx_rd),
    .dout    (q_head),
    .empty   (q_empty),
    .full    (q_full),
    .drained (q_drained)
  );

  sio_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ien     (ien),
    .rx_set  (rx_valid),
    .rx_clr  (q_drained),
    .th_set  (ev_tx_wr),
    .ms_set  (1'b0),
    .id_rd   (ev_id_rd),
    .code    (code),
    .rx_pend (rx_pend),
    .th_pend (th_pend),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo <= '0;
      div_hi <= '0;
      ien    <= '0;
      lctl   <= '0;
      fctl   <= '0;
      mctl   <= '0;
      scr    <= '0;
    end else if (wr_en) begin
      if (ev_div_lo_wr) div_lo <= wdata;
      if (ev_div_hi_wr) div_hi <= wdata;
      if (ev_ien_wr)    ien    <= wdata[3:0];
      case (addr)
        OFS_ID:   fctl <= wdata;
        OFS_LCTL: lctl <= wdata;
        OFS_MCTL: mctl <= wdata;
        OFS_SCR:  scr  <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= ev_tx_wr && (wdata != NO_SEND);
      if (ev_tx_wr) tx_byte <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_DATA: rdata = latch ? div_lo : q_head;
        OFS_IEN:  rdata = latch ? div_hi : {4'b0000, ien};
        OFS_ID:   rdata = id_read(code);
        OFS_LCTL: rdata = lctl;
        OFS_MCTL: rdata = mctl;
        OFS_LSTS: rdata = lsts_value(!q_empty);
        OFS_MSTS: rdata = msts;
        default:  rdata = scr;
      endcase
    end
  end

  AST_TX_NO_FF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_byte != NO_SEND));  // R5
  AST_LATCH_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DATA && latch) |=> !tx_valid);  // R3
  AST_FCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ID) |=> (fctl == $past(wdata)));  // R2
  AST_RXPEND_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pend |-> !q_empty);  // R6
  AST_FULL_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> rx_pend);  // R8
  AST_THR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_wr |=> th_pend);  // R5

endmodule

// File: tb/sio_host_regs_tb.sv
module sio_host_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  // {is_read, offset, data, expected}: R2, R3, R4 register access
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h1B, 8'h00}, {1'b1, 3'd3, 8'h00, 8'h1B},
    {1'b0, 3'd4, 8'h0A, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h0A},
    {1'b0, 3'd7, 8'h5A, 8'h00}, {1'b1, 3'd7, 8'h00, 8'h5A},
    {1'b0, 3'd5, 8'hFF, 8'h00}, {1'b1, 3'd5, 8'h00, 8'h60},
    {1'b0, 3'd6, 8'h33, 8'h00}, {1'b1, 3'd6, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'hF7, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h07},
    {1'b0, 3'd3, 8'h80, 8'h00}, {1'b0, 3'd0, 8'h34, 8'h00},
    {1'b0, 3'd1, 8'h12, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h34},
    {1'b1, 3'd1, 8'h00, 8'h12}, {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h07}, {1'b0, 3'd2, 8'hC7, 8'h00},
    {1'b1, 3'd3, 8'h00, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd2, 8'h00, 8'hC1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 check(tag, rdata, exp);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    rd(3'd5, 8'h60, "R1 line status");
    rd(3'd2, 8'hC1, "R1 ident");
    rd(3'd0, 8'h00, "R1 data");
    rd(3'd1, 8'h00, "R1 enables");
    rd(3'd3, 8'h00, "R1 line control");
    rd(3'd4, 8'h00, "R1 modem control");
    rd(3'd6, 8'h00, "R1 modem status");
    rd(3'd7, 8'h00, "R1 scratch");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rd(VEC[i][18:16], VEC[i][7:0], $sformatf("R2 R3 R4 vector %0d", i));
      else begin
        wr(VEC[i][18:16], VEC[i][15:8]);
        check($sformatf("R3 no send vector %0d", i), {7'b0, tx_valid}, 8'h00);
      end
    end

    // R5 transmit path, R11 irq lag, R9 code, R10 clear on read
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h41);
    check("R5 tx_valid", {7'b0, tx_valid}, 8'h01);
    check("R5 tx_byte", tx_byte, 8'h41);
    check("R11 irq still low", {7'b0, irq}, 8'h00);
    tick();
    check("R5 single pulse", {7'b0, tx_valid}, 8'h00);
    check("R11 irq high", {7'b0, irq}, 8'h01);
    rd(3'd2, 8'hC2, "R9 transmit code");
    rd(3'd2, 8'hC1, "R10 cleared by read");
    tick();
    check("R11 irq low", {7'b0, irq}, 8'h00);

    wr(3'd0, 8'hFF);
    check("R5 FF not sent", {7'b0, tx_valid}, 8'h00);
    rd(3'd2, 8'hC2, "R5 FF sets pending");
    rd(3'd2, 8'hC1, "R10 FF cleared");

    wr(3'd1, 8'h00);
    wr(3'd0, 8'h55);
    rd(3'd2, 8'hC1, "R9 disabled source");
    wr(3'd1, 8'h02);
    rd(3'd2, 8'hC2, "R9 pending kept");
    rd(3'd2, 8'hC1, "R10 clear after enable");

    // R6/R7 receive path, R9 priority, R10 no clear on other code
    push(8'h11); push(8'h22); push(8'h33);
    rd(3'd5, 8'h61, "R6 data ready");
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h66);
    rd(3'd2, 8'hCC, "R9 receive over transmit");
    rd(3'd0, 8'h11, "R7 order first");
    rd(3'd0, 8'h22, "R7 order second");
    rd(3'd0, 8'h33, "R7 order third");
    rd(3'd5, 8'h60, "R7 drained");
    rd(3'd2, 8'hC2, "R10 transmit kept");
    rd(3'd2, 8'hC1, "R10 transmit cleared");
    rd(3'd0, 8'h00, "R7 empty read");

    // R8 overflow
    for (int i = 0; i < 18; i++) push(8'(8'h80 + i));
    rd(3'd2, 8'hCC, "R6 receive code");
    for (int i = 0; i < 16; i++) rd(3'd0, 8'(8'h80 + i), $sformatf("R8 entry %0d", i));
    rd(3'd5, 8'h60, "R8 nothing past 16");
    rd(3'd2, 8'hC1, "R7 receive pending cleared");

    // R3 latch set: offset 0 gives divisor, no pop
    push(8'h77);
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h34, "R3 divisor low");
    rd(3'd5, 8'h61, "R3 no pop");
    wr(3'd3, 8'h00);
    rd(3'd0, 8'h77, "R3 data after latch");

    // R12 write and arrival in the same cycle
    @(negedge clk);
    addr = 3'd7; wdata = 8'h99; wr_en = 1'b1;
    rx_byte = 8'hAB; rx_valid = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; rx_valid = 1'b0;
    rd(3'd7, 8'h99, "R12 write applied");
    rd(3'd0, 8'hAB, "R12 byte queued");

    @(negedge clk);
    addr = 3'd0; wdata = 8'h5C; wr_en = 1'b1;
    rx_byte = 8'hCD; rx_valid = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; rx_valid = 1'b0;
    check("R12 sent", tx_byte, 8'h5C);
    rd(3'd0, 8'hCD, "R12 received");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule